// File: doc/BRIEF.md
# Data-side memory fault status capture

This block sits beside the data-side address translation path. When that path reports a memory-management fault, the block records three diagnostic values:

- a status word that describes the fault;
- the virtual address that faulted;
- a page-table entry address derived from that virtual address.

After a capture the block holds the three values. Later faults cannot overwrite them until the fault handler reads the captured virtual address, which releases the hold. While the fault strobe is high, the block also reports a handler-selection code. That code separates ordinary data faults, ordinary translation misses, and translation misses raised by a page-table-entry load.

A small parity error status register shares the same read path. Its error flags are cleared by writing ones, and the whole register is wiped once no error flag remains set.

Top module: `mm_fault_capture`

## Requirements
- R1: A fault strobe seen while unlocked loads the status word, the fault address and the formatted address at that clock edge, and `locked_o` is high from the next cycle.
- R2: A fault strobe seen while locked leaves all three captured values unchanged.
- R3: A read at read address 1 (captured address) returns the captured virtual address in the same cycle, and the lock is clear from the next cycle.
- R4: Reads at read address 0 (status), 2 (formatted address) and 3 (parity status) return their register and leave the lock unchanged. When `rd_en_i` is low, `rd_data_o` is zero.
- R5: The status word holds the following fields, with the upper read bits zero:
  - bit 0: write flag;
  - bits 4:1: the cause as one-hot, with cause code 0 (access violation) on bit 1, 1 (bad address) on bit 2, 2 (fault on read) on bit 3 and 3 (translation miss) on bit 4;
  - bits 15:5: the 11 instruction bits.
- R6: The formatted address is the page-table base ORed with one of two address fields:
  - with `fmt_sel_i`=0: fault address bits 42:13, shifted left by 3;
  - with `fmt_sel_i`=1: fault address bits 31:22, shifted left by 2.
- R7: `vec_o` is combinational from the fault inputs:
  - 2 for a translation miss with `pte_load_i` set;
  - 1 for a translation miss without `pte_load_i`;
  - 0 for any other cause.
  The status word is the same for both kinds of translation miss.
- R8: Parity status bits 1:0 are error flags. `perr_set_i` sets them and loads `perr_info_i` into bits 5:2. A `perr_clr_i` write clears each flag whose data bit is one. Data bits 5:2 of that write have no effect. When a set and a clear hit the same flag in one cycle, the set wins.
- R9: When a clear leaves no error flag set, the whole parity status register, including bits 5:2, becomes zero.
- R10: Same-cycle collision between a fault and a captured-address read:
  - while locked, the fault is dropped and the lock clears;
  - while unlocked, the fault is captured, the read returns the prior address, and the lock stays set.
- R11: After reset, all captured values and the parity status are zero and the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | 1 | Fault strobe, one cycle per fault |
| cause_i | input | 2 | Cause code: 0 access violation, 1 bad address, 2 fault on read, 3 translation miss |
| is_write_i | input | 1 | Faulting access was a write |
| pte_load_i | input | 1 | Fault raised by a page-table-entry load |
| fault_va_i | input | VA_W | Faulting virtual address |
| instr_bits_i | input | IB_W | Instruction bits merged into the status word |
| ptb_i | input | VA_W | Page-table base |
| fmt_sel_i | input | 1 | Formatting select for the page-table entry address |
| vec_o | output | 2 | Handler selection code |
| locked_o | output | 1 | Captured values are held |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Read address: 0 status, 1 address, 2 formatted address, 3 parity status |
| rd_data_o | output | VA_W | Read data, zero-extended |
| perr_set_i | input | FLAG_W | Parity error flags to set |
| perr_info_i | input | INFO_W | Parity error detail loaded with a set |
| perr_clr_i | input | 1 | Write-one-to-clear strobe for parity status |
| perr_clr_data_i | input | FLAG_W+INFO_W | Write data for the clear |

## Verification
A fault strobe and a read of the captured address can reach the capture logic in the same cycle. The result depends on whether the lock was already held. The bench provokes both orderings: once with the lock held from an earlier capture, and once right after a release. It judges each case by the data returned in that cycle, by `locked_o` one cycle later, and by a further read that shows whether the new fault was stored.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  typedef enum logic [1:0] {
    CAUSE_ACV = 2'd0,
    CAUSE_BVA = 2'd1,
    CAUSE_FOR = 2'd2,
    CAUSE_TBM = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    RA_STATUS = 2'd0,
    RA_VA     = 2'd1,
    RA_FORM   = 2'd2,
    RA_PERR   = 2'd3
  } rd_addr_e;

  typedef enum logic [1:0] {
    VEC_DFAULT   = 2'd0,
    VEC_DTBM     = 2'd1,
    VEC_DTBM_PTE = 2'd2
  } vec_e;

  localparam int unsigned CAUSE_N = 4;
endpackage

// File: rtl/mfc_format.sv
module mfc_format #(
  parameter int unsigned VA_W    = 64,
  parameter int unsigned PAGE_SH = 13,
  parameter int unsigned F0_W    = 30,
  parameter int unsigned F0_SH   = 3,
  parameter int unsigned F1_LO   = 22,
  parameter int unsigned F1_W    = 10,
  parameter int unsigned F1_SH   = 2
) (
  input  logic [VA_W-1:0] va_i,
  input  logic [VA_W-1:0] ptb_i,
  input  logic            sel_i,
  output logic [VA_W-1:0] form_o
);
  localparam logic [VA_W-1:0] M0 = {{(VA_W-F0_W){1'b0}}, {F0_W{1'b1}}};
  localparam logic [VA_W-1:0] M1 = {{(VA_W-F1_W){1'b0}}, {F1_W{1'b1}}};

  logic [VA_W-1:0] fld0, fld1;

  always_comb begin
    fld0 = ((va_i >> PAGE_SH) & M0) << F0_SH;
    fld1 = ((va_i >> F1_LO) & M1) << F1_SH;
    form_o = ptb_i | (sel_i ? fld1 : fld0);
  end
endmodule

// File: rtl/mfc_capture.sv
module mfc_capture #(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic              rel_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [VA_W-1:0]   form_i,
  output logic              lock_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [VA_W-1:0]   va_o,
  output logic [VA_W-1:0]   form_o
);
  logic take;
  assign take = fault_i && !lock_o;

  // capture wins over release when unlocked; release wins when locked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o <= 1'b0;
      stat_o <= '0;
      va_o   <= '0;
      form_o <= '0;
    end else if (take) begin
      lock_o <= 1'b1;
      stat_o <= stat_i;
      va_o   <= va_i;
      form_o <= form_i;
    end else if (rel_i) begin
      lock_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mfc_perr.sv
module mfc_perr #(
  parameter int unsigned FLAG_W = 2,
  parameter int unsigned INFO_W = 4,
  localparam int unsigned PW    = FLAG_W + INFO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [INFO_W-1:0] info_i,
  input  logic              clr_i,
  input  logic [PW-1:0]     clr_data_i,
  output logic [PW-1:0]     perr_o
);
  logic [FLAG_W-1:0] flags_q, flags_d, clr_m;
  logic [INFO_W-1:0] info_q, info_d;

  assign flags_q = perr_o[FLAG_W-1:0];
  assign info_q  = perr_o[PW-1:FLAG_W];

  always_comb begin
    clr_m   = clr_i ? clr_data_i[FLAG_W-1:0] : '0;
    flags_d = (flags_q & ~clr_m) | set_i;
    info_d  = (|set_i) ? info_i : info_q;
    if (flags_d == '0) info_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) perr_o <= '0;
    else         perr_o <= {info_d, flags_d};
  end
endmodule

// File: rtl/mm_fault_capture.sv
module mm_fault_capture #(
  parameter int unsigned VA_W    = 64,
  parameter int unsigned IB_W    = 11,
  parameter int unsigned PAGE_SH = 13,
  parameter int unsigned F0_W    = 30,
  parameter int unsigned F1_LO   = 22,
  parameter int unsigned F1_W    = 10,
  parameter int unsigned FLAG_W  = 2,
  parameter int unsigned INFO_W  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fault_i,
  input  logic [1:0]               cause_i,
  input  logic                     is_write_i,
  input  logic                     pte_load_i,
  input  logic [VA_W-1:0]          fault_va_i,
  input  logic [IB_W-1:0]          instr_bits_i,
  input  logic [VA_W-1:0]          ptb_i,
  input  logic                     fmt_sel_i,
  output logic [1:0]               vec_o,
  output logic                     locked_o,
  input  logic                     rd_en_i,
  input  logic [1:0]               rd_addr_i,
  output logic [VA_W-1:0]          rd_data_o,
  input  logic [FLAG_W-1:0]        perr_set_i,
  input  logic [INFO_W-1:0]        perr_info_i,
  input  logic                     perr_clr_i,
  input  logic [FLAG_W+INFO_W-1:0] perr_clr_data_i
);
  import mfc_pkg::*;

  localparam int unsigned STAT_W = 1 + CAUSE_N + IB_W;
  localparam int unsigned PW     = FLAG_W + INFO_W;

  logic [CAUSE_N-1:0] cause_oh;
  logic [STAT_W-1:0]  stat_new, cap_stat;
  logic [VA_W-1:0]    form_new, cap_va, cap_form;
  logic [PW-1:0]      perr_q;
  logic               rd_va;
  cause_e             cause;
  rd_addr_e           raddr;

  assign cause = cause_e'(cause_i);
  assign raddr = rd_addr_e'(rd_addr_i);

  for (genvar g = 0; g < CAUSE_N; g++) begin : g_oh
    assign cause_oh[g] = (cause_i == g[1:0]);
  end

  assign stat_new = {instr_bits_i, cause_oh, is_write_i};

  always_comb begin
    if (cause == CAUSE_TBM) vec_o = pte_load_i ? VEC_DTBM_PTE : VEC_DTBM;
    else                    vec_o = VEC_DFAULT;
  end

  mfc_format #(
    .VA_W(VA_W), .PAGE_SH(PAGE_SH), .F0_W(F0_W), .F0_SH(3),
    .F1_LO(F1_LO), .F1_W(F1_W), .F1_SH(2)
  ) u_fmt (
    .va_i(fault_va_i), .ptb_i(ptb_i), .sel_i(fmt_sel_i), .form_o(form_new)
  );

  assign rd_va = rd_en_i && (raddr == RA_VA);

  mfc_capture #(.VA_W(VA_W), .STAT_W(STAT_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .rel_i(rd_va),
    .stat_i(stat_new), .va_i(fault_va_i), .form_i(form_new),
    .lock_o(locked_o), .stat_o(cap_stat), .va_o(cap_va), .form_o(cap_form)
  );

  mfc_perr #(.FLAG_W(FLAG_W), .INFO_W(INFO_W)) u_perr (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(perr_set_i), .info_i(perr_info_i),
    .clr_i(perr_clr_i), .clr_data_i(perr_clr_data_i), .perr_o(perr_q)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      unique case (raddr)
        RA_STATUS: rd_data_o = VA_W'(cap_stat);
        RA_VA:     rd_data_o = cap_va;
        RA_FORM:   rd_data_o = cap_form;
        RA_PERR:   rd_data_o = VA_W'(perr_q);
        default:   rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mm_fault_capture_chk.sv
module mm_fault_capture_chk #(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned STAT_W = 16,
  parameter int unsigned FLAG_W = 2,
  parameter int unsigned PW     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fault_i,
  input logic [1:0]        cause_i,
  input logic              is_write_i,
  input logic              pte_load_i,
  input logic [VA_W-1:0]   fault_va_i,
  input logic [1:0]        vec_o,
  input logic              locked_o,
  input logic              rd_en_i,
  input logic [1:0]        rd_addr_i,
  input logic [STAT_W-1:0] cap_stat,
  input logic [VA_W-1:0]   cap_va,
  input logic [VA_W-1:0]   cap_form,
  input logic [FLAG_W-1:0] perr_set_i,
  input logic [PW-1:0]     perr_q
);
  logic rd_va;
  assign rd_va = rd_en_i && (rd_addr_i == 2'd1);

  a_r1_capture_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i && !locked_o |=> locked_o && cap_va == $past(fault_va_i));

  a_r2_hold_when_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i && locked_o |=> $stable(cap_va) && $stable(cap_stat) && $stable(cap_form));

  a_r3_va_read_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_va && locked_o |=> !locked_o);

  a_r4_other_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i != 2'd1 && locked_o |=> locked_o);

  a_r5_write_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i && !locked_o |=> cap_stat[0] == $past(is_write_i));

  a_r7_vec_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |-> ((cause_i == 2'd3) ? (vec_o == (pte_load_i ? 2'd2 : 2'd1)) : (vec_o == 2'd0)));

  a_r8_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |perr_set_i |=> (perr_q[FLAG_W-1:0] & $past(perr_set_i)) == $past(perr_set_i));

  a_r9_wipe_when_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_q[FLAG_W-1:0] == '0 |-> perr_q == '0);
endmodule

bind mm_fault_capture mm_fault_capture_chk #(
  .VA_W(VA_W), .STAT_W(STAT_W), .FLAG_W(FLAG_W), .PW(PW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .cause_i(cause_i),
  .is_write_i(is_write_i), .pte_load_i(pte_load_i), .fault_va_i(fault_va_i),
  .vec_o(vec_o), .locked_o(locked_o), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
  .cap_stat(cap_stat), .cap_va(cap_va), .cap_form(cap_form),
  .perr_set_i(perr_set_i), .perr_q(perr_q)
);

// File: tb/mm_fault_capture_tb.sv
module mm_fault_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault = 1'b0;
  logic [1:0]  cause = '0;
  logic        wr = 1'b0;
  logic        pte = 1'b0;
  logic [63:0] va = '0;
  logic [10:0] ib = '0;
  logic [63:0] ptb = '0;
  logic        fmt = 1'b0;
  logic [1:0]  vec;
  logic        locked;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic [1:0]  pset = '0;
  logic [3:0]  pinfo = '0;
  logic        pclr = 1'b0;
  logic [5:0]  pclr_d = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mm_fault_capture u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(fault), .cause_i(cause),
    .is_write_i(wr), .pte_load_i(pte), .fault_va_i(va), .instr_bits_i(ib),
    .ptb_i(ptb), .fmt_sel_i(fmt), .vec_o(vec), .locked_o(locked),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .perr_set_i(pset), .perr_info_i(pinfo), .perr_clr_i(pclr),
    .perr_clr_data_i(pclr_d)
  );

  typedef struct packed {
    logic [1:0]  cause;
    logic        wr;
    logic        pte;
    logic [63:0] va;
    logic [10:0] ib;
    logic [63:0] ptb;
    logic        fmt;
    logic [15:0] st;
    logic [63:0] form;
    logic [1:0]  vec;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_2000, 11'h155, 64'h0000_0001_0000_0000, 1'b0,
      16'h2AA2, 64'h0000_0001_0000_0008, 2'd0},
    '{2'd1, 1'b1, 1'b0, 64'h0000_0000_0040_0000, 11'h7FF, 64'h0000_0002_0000_0000, 1'b1,
      16'hFFE5, 64'h0000_0002_0000_0004, 2'd0},
    '{2'd3, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 11'h001, 64'h0, 1'b0,
      16'h0030, 64'h0000_0001_FFFF_FFF8, 2'd2},
    '{2'd3, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 11'h400, 64'hF000_0000_0000_0000, 1'b1,
      16'h8011, 64'hF000_0000_0000_0FFC, 2'd1},
    '{2'd2, 1'b1, 1'b0, 64'h0000_0000_1234_5678, 11'h000, 64'h8000_0000_0000_0000, 1'b0,
      16'h0009, 64'h8000_0000_0004_8D10, 2'd0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // call at a negedge; returns at the next negedge
  task automatic put_fault(input vec_t v);
    fault = 1'b1; cause = v.cause; wr = v.wr; pte = v.pte;
    va = v.va; ib = v.ib; ptb = v.ptb; fmt = v.fmt;
    #1 chk("R7 vec", 64'(vec), 64'(v.vec));
    @(negedge clk);
    fault = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 lock", 64'(locked), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R11 reg", d, 64'd0);
    end
    rd_addr = 2'd0;
    #1 chk("R4 idle read zero", rd_data, 64'd0);

    // table walk: R1 R5 R6 R7 R3 R4
    for (int i = 0; i < NV; i++) begin
      put_fault(TBL[i]);
      chk("R1 lock set", 64'(locked), 64'd1);
      rd(2'd0, d);
      chk("R5 status", d, 64'(TBL[i].st));
      chk("R4 lock after status read", 64'(locked), 64'd1);
      rd(2'd2, d);
      chk("R6 form", d, TBL[i].form);
      chk("R4 lock after form read", 64'(locked), 64'd1);
      rd(2'd1, d);
      chk("R3 va", d, TBL[i].va);
      chk("R3 lock released", 64'(locked), 64'd0);
    end

    // R2 locked fault ignored
    put_fault(TBL[0]);
    put_fault(TBL[1]);
    rd(2'd0, d);
    chk("R2 status held", d, 64'(TBL[0].st));
    rd(2'd2, d);
    chk("R2 form held", d, TBL[0].form);
    rd(2'd1, d);
    chk("R2 va held", d, TBL[0].va);

    // R10 locked: fault and va read together -> fault dropped, lock clear
    put_fault(TBL[2]);
    fault = 1'b1; cause = TBL[3].cause; wr = TBL[3].wr; pte = TBL[3].pte;
    va = TBL[3].va; ib = TBL[3].ib; ptb = TBL[3].ptb; fmt = TBL[3].fmt;
    rd(2'd1, d);
    fault = 1'b0;
    chk("R10 locked read data", d, TBL[2].va);
    chk("R10 locked lock clear", 64'(locked), 64'd0);
    rd(2'd0, d);
    chk("R10 locked fault dropped", d, 64'(TBL[2].st));

    // R10 unlocked: fault and va read together -> captured, lock stays
    fault = 1'b1; cause = TBL[4].cause; wr = TBL[4].wr; pte = TBL[4].pte;
    va = TBL[4].va; ib = TBL[4].ib; ptb = TBL[4].ptb; fmt = TBL[4].fmt;
    rd(2'd1, d);
    fault = 1'b0;
    chk("R10 unlocked read prior", d, TBL[2].va);
    chk("R10 unlocked lock set", 64'(locked), 64'd1);
    rd(2'd1, d);
    chk("R10 unlocked captured", d, TBL[4].va);

    // R8 parity set with info
    pset = 2'b01; pinfo = 4'hA;
    @(negedge clk);
    pset = '0;
    rd(2'd3, d);
    chk("R8 set", d, 64'h29);
    chk("R4 lock after perr read", 64'(locked), 64'd0);
    // R8 info bits not clearable
    pclr = 1'b1; pclr_d = 6'h3C;
    @(negedge clk);
    pclr = 1'b0;
    rd(2'd3, d);
    chk("R8 info write ignored", d, 64'h29);
    // R8 set beats clear on same flag
    pset = 2'b10; pinfo = 4'h5; pclr = 1'b1; pclr_d = 6'h02;
    @(negedge clk);
    pset = '0; pclr = 1'b0;
    rd(2'd3, d);
    chk("R8 set wins", d, 64'h17);
    // R8 partial clear keeps info
    pclr = 1'b1; pclr_d = 6'h01;
    @(negedge clk);
    pclr = 1'b0;
    rd(2'd3, d);
    chk("R8 partial clear", d, 64'h16);
    // R9 last flag cleared wipes register
    pclr = 1'b1; pclr_d = 6'h02;
    @(negedge clk);
    pclr = 1'b0;
    rd(2'd3, d);
    chk("R9 wipe", d, 64'h0);

    // R11 reset mid-run
    put_fault(TBL[1]);
    rst_n = 1'b0;
    #1 chk("R11 lock after reset", 64'(locked), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    rd(2'd1, d);
    chk("R11 va after reset", d, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule